// File: doc/BRIEF.md
# USB OTG Interrupt Aggregator

This block sits between a USB on-the-go controller core and a CPU. It gathers three families of event strobes (per-endpoint transmit, per-endpoint receive, and controller-level USB events) into one 32-bit pending word. Software sees that word, an enable word and their intersection through a small 32-bit register window. Software changes the pending word and the enable word only through separate write-one-to-set and write-one-to-clear locations, so no read-modify-write is ever needed.

A single interrupt line leaves the block as a one-cycle pulse. Once it has pulsed, the line stays quiet until software writes the end-of-interrupt location. Then it pulses again on the next clock if any enabled pending bit remains. Software can also inject any legal pending bit itself, for instance the VBUS-drive event, to start a polling flow. A control word carries a self-clearing soft-reset bit. A fixed identification word and a status word that reflects the core's VBUS-drive indication complete the window.

Top module: `usbirq_agg`

## Requirements
- R1: After reset the pending word, the enable word and the control word read 0 and the interrupt line is low.
- R2: Transmit event i sets pending bit i (bits 0 to 4). Receive event j sets pending bit 9+j (bits 9 to 12). Controller event k sets pending bit 16+k (bits 16 to 24, with VBUS-drive at bit 24). All other bits of the pending and enable words always read 0, so the legal-bit pattern is 0x01FF_1E1F.
- R3: A write to the set location 0x24 sets the pending bits written as 1 and leaves the others unchanged. A direct write to the pending location 0x20 is ignored.
- R4: A write to the clear location 0x28 clears the pending bits written as 1. An event arriving in the same cycle as a clear of its bit leaves the bit set.
- R5: Writes to 0x30 and 0x34 set and clear enable bits written as 1. The enable word reads at 0x2C, and a direct write there is ignored.
- R6: Location 0x38 reads as the pending word ANDed with the enable word.
- R7: The interrupt line pulses high for exactly one cycle. It is high in the cycle after a clock edge at which the line is armed and the masked word is nonzero. After a pulse it stays low until a write of any value to 0x3C re-arms it, and it then pulses on the clock after that write if the masked word is nonzero.
- R8: Writing 1 to bit 0 of the control location 0x04 makes that bit read 1 for exactly one cycle. At the following edge the pending and enable words clear, the line re-arms, and events presented in that cycle are dropped.
- R9: Location 0x08 reads the VBUS-drive input in bit 0 and 0 in all other bits.
- R10: Location 0x00 reads the fixed nonzero identification value 0x5A01_0203, and writes to it are ignored. Unmapped locations read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| tx_evt | input | TX_EPS | Transmit endpoint event strobes |
| rx_evt | input | RX_EPS | Receive endpoint event strobes |
| core_evt | input | CORE_EVTS | Controller-level event strobes |
| vbus_drv_i | input | 1 | VBUS-drive indication from the core |
| irq_o | output | 1 | Interrupt pulse to the CPU |

## Verification
The assertions check on every cycle that the line never pulses twice without an end-of-interrupt write in between. They also check that set, clear and event inputs land in the pending word as required, that illegal bits stay zero, that the soft reset empties both words, and that the masked view matches its operands. Only the bench's scenarios show read values at each address, the ignored writes, the status bit, and the exact pulse timing after an end-of-interrupt write. The bench checks these both in directed collisions and in a long random mix of traffic.

// File: rtl/usbirq_pkg.sv
package usbirq_pkg;

   localparam logic [7:0] A_IDENT   = 8'h00;
   localparam logic [7:0] A_CTRL    = 8'h04;
   localparam logic [7:0] A_STATUS  = 8'h08;
   localparam logic [7:0] A_PEND    = 8'h20;
   localparam logic [7:0] A_PEND_S  = 8'h24;
   localparam logic [7:0] A_PEND_C  = 8'h28;
   localparam logic [7:0] A_ENA     = 8'h2C;
   localparam logic [7:0] A_ENA_S   = 8'h30;
   localparam logic [7:0] A_ENA_C   = 8'h34;
   localparam logic [7:0] A_MASKED  = 8'h38;
   localparam logic [7:0] A_EOI     = 8'h3C;

   localparam int TX_LSB   = 0;
   localparam int RX_LSB   = 9;
   localparam int CORE_LSB = 16;

   typedef struct packed {
      logic ctrl;
      logic pend_set;
      logic pend_clr;
      logic ena_set;
      logic ena_clr;
      logic eoi;
   } wr_strobe_t;

   function automatic logic [31:0] legal_bits(input int n_tx, input int n_rx, input int n_core);
      logic [31:0] v;
      v = '0;
      for (int i = 0; i < n_tx; i++)   v[TX_LSB + i]   = 1'b1;
      for (int i = 0; i < n_rx; i++)   v[RX_LSB + i]   = 1'b1;
      for (int i = 0; i < n_core; i++) v[CORE_LSB + i] = 1'b1;
      return v;
   endfunction

endpackage

// File: rtl/usbirq_regdec.sv
module usbirq_regdec
   import usbirq_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   output wr_strobe_t        strb
);
   always_comb begin
      strb          = '0;
      strb.ctrl     = wr_en && (addr == ADDR_W'(A_CTRL));
      strb.pend_set = wr_en && (addr == ADDR_W'(A_PEND_S));
      strb.pend_clr = wr_en && (addr == ADDR_W'(A_PEND_C));
      strb.ena_set  = wr_en && (addr == ADDR_W'(A_ENA_S));
      strb.ena_clr  = wr_en && (addr == ADDR_W'(A_ENA_C));
      strb.eoi      = wr_en && (addr == ADDR_W'(A_EOI));
   end
endmodule

// File: rtl/usbirq_bitreg.sv
module usbirq_bitreg #(
   parameter int           W    = 32,
   parameter logic [W-1:0] KEEP = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_all,
   input  logic [W-1:0] set_bits,
   input  logic [W-1:0] clr_bits,
   input  logic [W-1:0] hw_bits,
   output logic [W-1:0] q
);
   logic [W-1:0] nxt;

   // Events and set writes are ORed after the clear, so an event wins
   // over a simultaneous clear of the same bit.
   always_comb nxt = ((q & ~clr_bits) | set_bits | hw_bits) & KEEP;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= '0;
      else if (clr_all) q <= '0;
      else              q <= nxt;
   end
endmodule

// File: rtl/usbirq_irqgen.sv
module usbirq_irqgen (
   input  logic clk,
   input  logic rst_n,
   input  logic srst,
   input  logic pend,
   input  logic eoi,
   output logic irq_o
);
   logic armed_q;
   logic fire;

   always_comb fire = armed_q && pend && !srst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b1;
         irq_o   <= 1'b0;
      end else begin
         irq_o <= fire;
         if (srst)      armed_q <= 1'b1;
         else if (fire) armed_q <= 1'b0;
         else if (eoi)  armed_q <= 1'b1;
      end
   end
endmodule

// File: rtl/usbirq_agg.sv
module usbirq_agg
   import usbirq_pkg::*;
#(
   parameter int          ADDR_W    = 8,
   parameter int          TX_EPS    = 5,
   parameter int          RX_EPS    = 4,
   parameter int          CORE_EVTS = 9,
   parameter logic [31:0] REV_ID    = 32'h5A01_0203
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_wr_en,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic [31:0]          reg_wdata,
   output logic [31:0]          reg_rdata,
   input  logic [TX_EPS-1:0]    tx_evt,
   input  logic [RX_EPS-1:0]    rx_evt,
   input  logic [CORE_EVTS-1:0] core_evt,
   input  logic                 vbus_drv_i,
   output logic                 irq_o
);
   localparam logic [31:0] VALID = legal_bits(TX_EPS, RX_EPS, CORE_EVTS);

   if (ADDR_W < 8 || ADDR_W > 16) begin : g_bad_addr
      $error("usbirq_agg: ADDR_W must be 8..16");
   end
   if (TX_EPS < 1 || TX_EPS > RX_LSB - 1) begin : g_bad_tx
      $error("usbirq_agg: TX_EPS out of range");
   end
   if (RX_EPS < 1 || RX_EPS > CORE_LSB - RX_LSB) begin : g_bad_rx
      $error("usbirq_agg: RX_EPS out of range");
   end
   if (CORE_EVTS < 1 || CORE_EVTS > 32 - CORE_LSB) begin : g_bad_core
      $error("usbirq_agg: CORE_EVTS out of range");
   end
   if (REV_ID == 32'h0) begin : g_bad_rev
      $error("usbirq_agg: REV_ID must be nonzero");
   end

   wr_strobe_t  strb;
   logic        srst_q;
   logic [31:0] hw_evt;
   logic [31:0] src_q;
   logic [31:0] mask_q;
   logic [31:0] masked;

   usbirq_regdec #(.ADDR_W(ADDR_W)) u_dec (
      .wr_en (reg_wr_en),
      .addr  (reg_addr),
      .strb  (strb)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) srst_q <= 1'b0;
      else        srst_q <= strb.ctrl && reg_wdata[0];
   end

   always_comb begin
      hw_evt = '0;
      hw_evt[TX_LSB   +: TX_EPS]    = tx_evt;
      hw_evt[RX_LSB   +: RX_EPS]    = rx_evt;
      hw_evt[CORE_LSB +: CORE_EVTS] = core_evt;
   end

   usbirq_bitreg #(.W(32), .KEEP(VALID)) u_src (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_all  (srst_q),
      .set_bits (strb.pend_set ? reg_wdata : 32'h0),
      .clr_bits (strb.pend_clr ? reg_wdata : 32'h0),
      .hw_bits  (hw_evt),
      .q        (src_q)
   );

   usbirq_bitreg #(.W(32), .KEEP(VALID)) u_mask (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_all  (srst_q),
      .set_bits (strb.ena_set ? reg_wdata : 32'h0),
      .clr_bits (strb.ena_clr ? reg_wdata : 32'h0),
      .hw_bits  (32'h0),
      .q        (mask_q)
   );

   always_comb masked = src_q & mask_q;

   usbirq_irqgen u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .srst  (srst_q),
      .pend  (|masked),
      .eoi   (strb.eoi),
      .irq_o (irq_o)
   );

   always_comb begin
      reg_rdata = '0;
      if      (reg_addr == ADDR_W'(A_IDENT))  reg_rdata = REV_ID;
      else if (reg_addr == ADDR_W'(A_CTRL))   reg_rdata = {31'h0, srst_q};
      else if (reg_addr == ADDR_W'(A_STATUS)) reg_rdata = {31'h0, vbus_drv_i};
      else if (reg_addr == ADDR_W'(A_PEND))   reg_rdata = src_q;
      else if (reg_addr == ADDR_W'(A_ENA))    reg_rdata = mask_q;
      else if (reg_addr == ADDR_W'(A_MASKED)) reg_rdata = masked;
   end
endmodule

// File: rtl/usbirq_agg_chk.sv
module usbirq_agg_chk
   import usbirq_pkg::*;
#(
   parameter int          ADDR_W = 8,
   parameter logic [31:0] VALID  = 32'hFFFF_FFFF
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr_en,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [31:0]       reg_wdata,
   input logic [31:0]       reg_rdata,
   input logic              irq_o,
   input logic [31:0]       src_q,
   input logic [31:0]       mask_q,
   input logic [31:0]       hw_evt,
   input logic              srst_q
);
   logic eoi_wr;
   logic waiting_q;

   always_comb eoi_wr = reg_wr_en && (reg_addr == ADDR_W'(A_EOI));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                waiting_q <= 1'b0;
      else if (eoi_wr || srst_q) waiting_q <= 1'b0;
      else if (irq_o)            waiting_q <= 1'b1;
   end

   assert_one_per_eoi_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> !waiting_q);

   assert_pulse_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |=> !irq_o);

   assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ((src_q | mask_q) & ~VALID) == 32'h0);

   assert_src_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && reg_addr == ADDR_W'(A_PEND_S) && !srst_q)
      |=> ((~src_q & $past(reg_wdata) & VALID) == 32'h0));

   assert_src_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && reg_addr == ADDR_W'(A_PEND_C))
      |=> ((src_q & $past(reg_wdata) & ~$past(hw_evt)) == 32'h0));

   assert_event_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((hw_evt != 32'h0) && !srst_q) |=> ((~src_q & $past(hw_evt)) == 32'h0));

   assert_soft_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
      srst_q |=> (src_q == 32'h0 && mask_q == 32'h0 && !srst_q));

   assert_masked_view_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(A_MASKED)) |-> (reg_rdata == (src_q & mask_q)));
endmodule

bind usbirq_agg usbirq_agg_chk #(.ADDR_W(ADDR_W), .VALID(VALID)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr_en (reg_wr_en),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .irq_o     (irq_o),
   .src_q     (src_q),
   .mask_q    (mask_q),
   .hw_evt    (hw_evt),
   .srst_q    (srst_q)
);

// File: tb/usbirq_agg_test.sv
module usbirq_agg_test;
   localparam int          CLK_PERIOD = 10;
   localparam int          WATCHDOG   = 100000;
   localparam logic [31:0] LEGAL      = 32'h01FF_1E1F;
   localparam logic [31:0] IDENT      = 32'h5A01_0203;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [7:0]  reg_addr = 8'h0;
   logic [31:0] reg_wdata = 32'h0;
   logic [31:0] reg_rdata;
   logic [4:0]  tx_evt = '0;
   logic [3:0]  rx_evt = '0;
   logic [8:0]  core_evt = '0;
   logic        vbus_drv_i = 1'b0;
   logic        irq_o;

   int n_chk = 0;
   int n_bad = 0;

   // reference state
   logic [31:0] src_m, mask_m;
   logic        armed_m, irq_m, srst_m;

   always #(CLK_PERIOD/2) clk = ~clk;

   usbirq_agg uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_wr_en  (reg_wr_en),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .tx_evt     (tx_evt),
      .rx_evt     (rx_evt),
      .core_evt   (core_evt),
      .vbus_drv_i (vbus_drv_i),
      .irq_o      (irq_o)
   );

   function automatic logic [31:0] exp_read(input logic [7:0] a, input logic vb);
      case (a)
         8'h00:   return IDENT;
         8'h04:   return {31'h0, srst_m};
         8'h08:   return {31'h0, vb};
         8'h20:   return src_m;
         8'h2C:   return mask_m;
         8'h38:   return src_m & mask_m;
         default: return 32'h0;
      endcase
   endfunction

   function automatic string tag_of(input logic [7:0] a);
      case (a)
         8'h00:   return "R10";
         8'h04:   return "R8";
         8'h08:   return "R9";
         8'h20:   return "R2";
         8'h2C:   return "R5";
         8'h38:   return "R6";
         default: return "R10";
      endcase
   endfunction

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic model_step(input logic wr, input logic [7:0] a, input logic [31:0] d,
                             input logic [31:0] ev);
      logic [31:0] set_s, clr_s, set_m, clr_m;
      logic        fire, eoi;
      set_s = (wr && a == 8'h24) ? d : 32'h0;
      clr_s = (wr && a == 8'h28) ? d : 32'h0;
      set_m = (wr && a == 8'h30) ? d : 32'h0;
      clr_m = (wr && a == 8'h34) ? d : 32'h0;
      eoi   = wr && a == 8'h3C;
      fire  = armed_m && ((src_m & mask_m) != 0) && !srst_m;
      irq_m = fire;
      if (srst_m) begin
         armed_m = 1'b1;
         src_m   = 32'h0;
         mask_m  = 32'h0;
      end else begin
         if (fire)     armed_m = 1'b0;
         else if (eoi) armed_m = 1'b1;
         src_m  = ((src_m & ~clr_s) | set_s | ev) & LEGAL;
         mask_m = ((mask_m & ~clr_m) | set_m) & LEGAL;
      end
      srst_m = wr && a == 8'h04 && d[0];
   endtask

   // Called at a falling edge; returns at the next falling edge.
   task automatic cycle(input logic wr, input logic [7:0] a, input logic [31:0] d,
                        input logic [31:0] ev, input logic vb, input string req);
      logic [31:0] e;
      e          = ev & LEGAL;
      reg_wr_en  = wr;
      reg_addr   = a;
      reg_wdata  = d;
      tx_evt     = e[4:0];
      rx_evt     = e[12:9];
      core_evt   = e[24:16];
      vbus_drv_i = vb;
      #1;
      check(reg_rdata, exp_read(a, vb), (req == "") ? tag_of(a) : req);
      check({31'h0, irq_o}, {31'h0, irq_m}, "R7");
      @(posedge clk);
      model_step(wr, a, d, e);
      @(negedge clk);
   endtask

   task automatic rd(input logic [7:0] a, input string req);
      cycle(1'b0, a, 32'h0, 32'h0, 1'b0, req);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d, input string req);
      cycle(1'b1, a, d, 32'h0, 1'b0, req);
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [7:0] addrs [12];
      addrs = '{8'h00, 8'h04, 8'h08, 8'h20, 8'h24, 8'h28, 8'h2C, 8'h30, 8'h34, 8'h38, 8'h3C, 8'h44};
      void'($urandom(32'd20240611));
      src_m = 0; mask_m = 0; armed_m = 1; irq_m = 0; srst_m = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      rd(8'h20, "R1");
      rd(8'h2C, "R1");
      rd(8'h04, "R1");
      // R10: identification, ignored write, unmapped
      rd(8'h00, "R10");
      wr(8'h00, 32'h1234_5678, "R10");
      rd(8'h00, "R10");
      rd(8'h40, "R10");
      // R9: status follows VBUS-drive
      cycle(1'b0, 8'h08, 32'h0, 32'h0, 1'b1, "R9");
      cycle(1'b0, 8'h08, 32'h0, 32'h0, 1'b0, "R9");
      // R2/R3: set everything, only legal bits stick
      wr(8'h24, 32'hFFFF_FFFF, "R3");
      rd(8'h20, "R2");
      // R4: clear all while transmit event 0 and controller event 3 arrive
      cycle(1'b1, 8'h28, 32'hFFFF_FFFF, 32'h0008_0001, 1'b0, "R4");
      rd(8'h20, "R4");
      // R3: direct write to pending ignored; zero bits of set write no effect
      wr(8'h20, 32'h0000_0000, "R3");
      wr(8'h24, 32'h0000_0000, "R3");
      rd(8'h20, "R3");
      // R2: receive events map from bit 9
      cycle(1'b0, 8'h20, 32'h0, 32'h0000_1200, 1'b0, "R2");
      rd(8'h20, "R2");
      // R5: enable set/clear, direct write ignored
      wr(8'h30, 32'hFFFF_FFFF, "R5");
      rd(8'h2C, "R5");
      wr(8'h2C, 32'h0, "R5");
      wr(8'h34, 32'hFEFF_FFFF, "R5");
      rd(8'h2C, "R5");
      // R6/R7: inject VBUS-drive (bit 24), pulse once, quiet until EOI
      rd(8'h38, "R6");
      wr(8'h24, 32'h0100_0000, "R7");
      repeat (5) rd(8'h38, "R7");
      wr(8'h3C, 32'h0, "R7");
      repeat (3) rd(8'h38, "R7");
      wr(8'h28, 32'h0100_0000, "R7");
      wr(8'h3C, 32'hDEAD_BEEF, "R7");
      repeat (3) rd(8'h38, "R7");
      // R8: soft reset self-clears and empties both words
      wr(8'h30, 32'h0000_0001, "R8");
      wr(8'h04, 32'h0000_0001, "R8");
      cycle(1'b0, 8'h04, 32'h0, 32'h0000_0002, 1'b0, "R8");
      rd(8'h04, "R8");
      rd(8'h20, "R8");
      rd(8'h2C, "R8");
      wr(8'h04, 32'h0000_0000, "R8");
      rd(8'h04, "R8");

      // random mix
      for (int i = 0; i < 4000; i++) begin
         logic [7:0]  a;
         logic [31:0] d, ev;
         logic        w;
         a  = addrs[$urandom_range(11, 0)];
         w  = ($urandom_range(3, 0) != 0);
         d  = $urandom();
         if (a == 8'h04 && $urandom_range(7, 0) != 0) d[0] = 1'b0;
         ev = ($urandom_range(3, 0) == 0) ? (32'h1 << $urandom_range(31, 0)) : 32'h0;
         cycle(w, a, d, ev, 1'($urandom_range(1, 0)), "");
      end
      finish_run();
   end
endmodule